// File: doc/BRIEF.md
# Hardware Error Record with Read-Gated Invalidate

This block holds one hardware error record. Error reports arrive on a single-cycle input carrying three severity flags (urgent uncorrectable, deferred uncorrectable, corrected) and an 8-bit error code. The first report into an empty record fills it. Later reports either replace the contents, when they are more severe, or only mark that more errors occurred. A 16-bit counter can tally corrected errors. An error-signal output tells the rest of the system that something was logged.

Software uses a two-register port to read the record safely. Register 0 is control and register 1 is status. The read sequence is:
1. Read status.
2. If the read-in-progress flag is clear, set it through a write-1 bit in control.
3. Read the record.
4. Write the invalidate bit.
5. Read status again.

Hardware clears read-in-progress whenever a new error lands on a valid record. The invalidate bit is honoured only while that flag is still set. So if status still shows valid after the invalidate, the record changed during the read and software repeats the sequence.

Top module: `err_record`

## Requirements
- R1: After reset, the status word, the control word and `errSignal` all read 0.
- R2: A report into an invalid record stores the flags with priority and stores the code unchanged. Urgent (status bit 1) is taken as given. Deferred (bit 2) is kept only without urgent. Corrected (bit 3) is kept only without the other two. The code may have bit 7 set (custom) or clear (standard). The same report also sets valid (bit 0), clears multiple-occurrence (bit 4) and sets read-in-progress (bit 10). The code sits at status bits 18:11.
- R3: A report onto a valid record sets multiple-occurrence and clears read-in-progress. The severity order is urgent > deferred > corrected. If the new severity is strictly higher, the flags and code are replaced. Otherwise they are kept.
- R4: Writing control bit 1 as 1 sets read-in-progress. Control bit 1 and control bit 2 always read back 0. Control bit 0 is the counter enable and reads back as written.
- R5: Writing control bit 2 as 1 clears valid only when read-in-progress is 1. Otherwise the record is unchanged.
- R6: When a report and a control write happen in the same cycle, the write is applied first and the capture last. An invalidate followed by a capture leaves valid=1, with read-in-progress following R2/R3.
- R7: With the counter enable set, each report whose highest flag is corrected increments the counter at status bits 35 and up. On overflow the counter wraps to 0 and sets the sticky overflow flag at bit 8.
- R8: `errSignal` is high for the one cycle after a report is captured, under one exception. For a corrected report while the counter is enabled, it goes high only when that report overflows the counter.
- R9: Writes to the status register have no effect. Reserved status bits (5, 6, 7, 9, 19–34 and above the counter) read 0.
- R10: A report with no severity flag set changes nothing and raises no signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errValid | input | 1 | Error report strobe |
| errUrgent | input | 1 | Report carries an urgent uncorrectable error |
| errDeferred | input | 1 | Report carries a deferred uncorrectable error |
| errCorrected | input | 1 | Report carries a corrected error |
| errCode | input | CODE_W | Error code of the report |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 control, 1 status |
| regWrData | input | 3 | Write data (control bits 2:0) |
| regRdData | output | 64 | Read data of the selected register |
| errSignal | output | 1 | Error signal pulse |

## Verification
The hardest situation to reach is an error arriving in the same cycle as the invalidate write, or in the same cycle as the read-in-progress set write. That collision decides whether software sees the overwrite. The bench sweeps every stored severity against every incoming severity, with read-in-progress both set and clear, and with and without a simultaneous invalidate. A long pseudo-random phase then mixes control writes and reports on the same cycles. Counter overflow is reached quickly by building the bench with a 4-bit counter.

// File: rtl/err_record_pkg.sv
package err_record_pkg;
  localparam int REG_W     = 64;
  localparam int CTRL_W    = 3;
  // control bit positions
  localparam int CEN_BIT   = 0;
  localparam int SRIP_BIT  = 1;
  localparam int INV_BIT   = 2;
  // status bit positions
  localparam int VALID_BIT = 0;
  localparam int URG_BIT   = 1;
  localparam int DEF_BIT   = 2;
  localparam int COR_BIT   = 3;
  localparam int MULTI_BIT = 4;
  localparam int OVF_BIT   = 8;
  localparam int RIP_BIT   = 10;
  localparam int CODE_LSB  = 11;
  localparam int CNT_LSB   = 35;

  typedef enum logic [1:0] {
    SEV_NONE   = 2'd0,
    SEV_CORR   = 2'd1,
    SEV_DEFER  = 2'd2,
    SEV_URGENT = 2'd3
  } sev_e;

  typedef struct packed {
    logic ctrlWr;
    logic invalidate;
    logic setRip;
    logic load;
    logic overwrite;
    logic markMulti;
    logic ctrInc;
    logic ctrWrap;
  } strobe_t;

  function automatic sev_e sevOf(input logic u, input logic d, input logic c);
    if (u) return SEV_URGENT;
    if (d) return SEV_DEFER;
    if (c) return SEV_CORR;
    return SEV_NONE;
  endfunction
endpackage

// File: rtl/err_record_ctrl.sv
module err_record_ctrl
  import err_record_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    errValid,
  input  logic    errUrgent,
  input  logic    errDeferred,
  input  logic    errCorrected,
  input  logic    regWrEn,
  input  logic    regAddr,
  input  logic    wrSetRip,
  input  logic    wrInvalidate,
  input  logic    valid,
  input  logic    readInProg,
  input  sev_e    storedSev,
  input  logic    ctrEnable,
  input  logic    cntAllOnes,
  output strobe_t strobe,
  output logic    errSignal
);
  sev_e newSev;
  logic report;
  logic effValid;
  logic higher;
  logic sigNext;

  always_comb begin
    newSev   = sevOf(errUrgent, errDeferred, errCorrected);
    report   = errValid && (newSev != SEV_NONE);
    higher   = newSev > storedSev;

    strobe.ctrlWr     = regWrEn && (regAddr == 1'b0);
    strobe.invalidate = strobe.ctrlWr && wrInvalidate;
    strobe.setRip     = strobe.ctrlWr && wrSetRip;

    // write is applied before the capture of the same cycle
    effValid = valid && !(strobe.invalidate && readInProg);

    strobe.load      = report && !effValid;
    strobe.overwrite = report && effValid && higher;
    strobe.markMulti = report && effValid && !higher;
    strobe.ctrInc    = report && (newSev == SEV_CORR) && ctrEnable;
    strobe.ctrWrap   = strobe.ctrInc && cntAllOnes;

    sigNext = report && ((newSev != SEV_CORR) || !ctrEnable || cntAllOnes);
  end

  always_ff @(posedge clk) begin
    if (!rstN) errSignal <= 1'b0;
    else       errSignal <= sigNext;
  end

  // R8
  sig_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    errSignal |-> $past(errValid));

  // R10
  no_flag_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && !errUrgent && !errDeferred && !errCorrected) |=> !errSignal);
endmodule

// File: rtl/err_record_data.sv
module err_record_data
  import err_record_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              errUrgent,
  input  logic              errDeferred,
  input  logic              errCorrected,
  input  logic [CODE_W-1:0] errCode,
  input  logic              wrEnable,
  output logic              valid,
  output logic              readInProg,
  output sev_e              storedSev,
  output logic              ctrEnable,
  output logic              cntAllOnes,
  output logic [REG_W-1:0]  statusWord,
  output logic [REG_W-1:0]  ctrlWord
);
  logic              urg;
  logic              dfr;
  logic              cor;
  logic              multiOcc;
  logic              ctrOvf;
  logic [CODE_W-1:0] code;
  logic [CNT_W-1:0]  cnt;
  logic              capture;

  assign capture = strobe.load || strobe.overwrite || strobe.markMulti;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid      <= 1'b0;
      readInProg <= 1'b0;
      urg        <= 1'b0;
      dfr        <= 1'b0;
      cor        <= 1'b0;
      multiOcc   <= 1'b0;
      ctrOvf     <= 1'b0;
      code       <= '0;
      cnt        <= '0;
      ctrEnable  <= 1'b0;
    end else begin
      if (strobe.ctrlWr) ctrEnable <= wrEnable;

      if (capture)                                  valid <= 1'b1;
      else if (strobe.invalidate && readInProg)     valid <= 1'b0;

      if (strobe.load)                              readInProg <= 1'b1;
      else if (strobe.overwrite || strobe.markMulti) readInProg <= 1'b0;
      else if (strobe.setRip)                       readInProg <= 1'b1;

      if (strobe.load || strobe.overwrite) begin
        urg  <= errUrgent;
        dfr  <= errDeferred && !errUrgent;
        cor  <= errCorrected && !errUrgent && !errDeferred;
        code <= errCode;
      end

      if (strobe.load)                                multiOcc <= 1'b0;
      else if (strobe.overwrite || strobe.markMulti)  multiOcc <= 1'b1;

      if (strobe.ctrInc)  cnt    <= cnt + 1'b1;
      if (strobe.ctrWrap) ctrOvf <= 1'b1;
    end
  end

  assign storedSev  = sevOf(urg, dfr, cor);
  assign cntAllOnes = &cnt;

  always_comb begin
    statusWord = '0;
    statusWord[VALID_BIT]             = valid;
    statusWord[URG_BIT]               = urg;
    statusWord[DEF_BIT]               = dfr;
    statusWord[COR_BIT]               = cor;
    statusWord[MULTI_BIT]             = multiOcc;
    statusWord[OVF_BIT]               = ctrOvf;
    statusWord[RIP_BIT]               = readInProg;
    statusWord[CODE_LSB +: CODE_W]    = code;
    statusWord[CNT_LSB +: CNT_W]      = cnt;
    ctrlWord = '0;
    ctrlWord[CEN_BIT]                 = ctrEnable;
  end

  // R2
  load_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (valid && readInProg && !multiOcc));

  // R3
  hit_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.overwrite || strobe.markMulti) |=> (valid && !readInProg && multiOcc));

  // R5
  gated_inv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.invalidate && !readInProg && !capture) |=> (valid == $past(valid)));

  // R7
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ctrInc && !cntAllOnes) |=> (cnt == $past(cnt) + 1'b1));

  // R2
  sev_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({urg, dfr, cor}));
endmodule

// File: rtl/err_record.sv
module err_record
  import err_record_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     errValid,
  input  logic                     errUrgent,
  input  logic                     errDeferred,
  input  logic                     errCorrected,
  input  logic [CODE_W-1:0]        errCode,
  input  logic                     regWrEn,
  input  logic                     regAddr,
  input  logic [CTRL_W-1:0]        regWrData,
  output logic [REG_W-1:0]         regRdData,
  output logic                     errSignal
);
  strobe_t          strobe;
  logic             valid;
  logic             readInProg;
  sev_e             storedSev;
  logic             ctrEnable;
  logic             cntAllOnes;
  logic [REG_W-1:0] statusWord;
  logic [REG_W-1:0] ctrlWord;

  err_record_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .errValid(errValid), .errUrgent(errUrgent),
    .errDeferred(errDeferred), .errCorrected(errCorrected),
    .regWrEn(regWrEn), .regAddr(regAddr),
    .wrSetRip(regWrData[SRIP_BIT]), .wrInvalidate(regWrData[INV_BIT]),
    .valid(valid), .readInProg(readInProg), .storedSev(storedSev),
    .ctrEnable(ctrEnable), .cntAllOnes(cntAllOnes),
    .strobe(strobe), .errSignal(errSignal)
  );

  err_record_data #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .errUrgent(errUrgent), .errDeferred(errDeferred),
    .errCorrected(errCorrected), .errCode(errCode),
    .wrEnable(regWrData[CEN_BIT]),
    .valid(valid), .readInProg(readInProg), .storedSev(storedSev),
    .ctrEnable(ctrEnable), .cntAllOnes(cntAllOnes),
    .statusWord(statusWord), .ctrlWord(ctrlWord)
  );

  assign regRdData = regAddr ? statusWord : ctrlWord;
endmodule

// File: tb/err_record_bench.sv
module err_record_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BCNT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic errValid = 0, errUrgent = 0, errDeferred = 0, errCorrected = 0;
  logic [7:0] errCode = '0;
  logic regWrEn = 0, regAddr = 1;
  logic [2:0] regWrData = '0;
  logic [63:0] regRdData;
  logic errSignal;

  int checks = 0;
  int errors = 0;

  // reference state
  logic mV, mU, mD, mC, mMo, mRip, mOvf, mEn, mSig;
  logic [7:0] mCode;
  logic [BCNT-1:0] mCnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_record #(.CODE_W(8), .CNT_W(BCNT)) u_err_record (
    .clk(clk), .rstN(rstN), .errValid(errValid), .errUrgent(errUrgent),
    .errDeferred(errDeferred), .errCorrected(errCorrected), .errCode(errCode),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .errSignal(errSignal)
  );

  function automatic logic [63:0] expStatus();
    logic [63:0] w = '0;
    w[0] = mV; w[1] = mU; w[2] = mD; w[3] = mC; w[4] = mMo;
    w[8] = mOvf; w[10] = mRip; w[18:11] = mCode;
    w[35 +: BCNT] = mCnt;
    return w;
  endfunction

  function automatic int sevNum(input logic u, input logic d, input logic c);
    return u ? 3 : d ? 2 : c ? 1 : 0;
  endfunction

  task automatic modelReset();
    mV = 0; mU = 0; mD = 0; mC = 0; mMo = 0; mRip = 0; mOvf = 0;
    mEn = 0; mSig = 0; mCode = '0; mCnt = '0;
  endtask

  task automatic modelStep(input logic ev, input logic u, input logic d,
                           input logic c, input logic [7:0] cd,
                           input logic we, input logic ad, input logic [2:0] wd);
    int ns = sevNum(u, d, c);
    logic rep = ev && (ns != 0);
    logic cw = we && !ad;
    logic inv = cw && wd[2];
    logic effV = mV && !(inv && mRip);
    logic inc = rep && (ns == 1) && mEn;
    mSig = rep && ((ns != 1) || !mEn || (mCnt == '1));
    if (inc) begin
      if (mCnt == '1) mOvf = 1;
      mCnt = mCnt + 1'b1;
    end
    if (inv && mRip) mV = 0;
    if (cw && wd[1]) mRip = 1;
    if (cw) mEn = wd[0];
    if (rep) begin
      if (!effV || ns > sevNum(mU, mD, mC)) begin
        mU = u; mD = d && !u; mC = c && !u && !d; mCode = cd;
      end
      mMo = effV; mRip = !effV; mV = 1;
    end
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive, clock, then compare status and signal
  task automatic step(input string tag, input logic ev, input logic u, input logic d,
                      input logic c, input logic [7:0] cd,
                      input logic we, input logic ad, input logic [2:0] wd);
    errValid = ev; errUrgent = u; errDeferred = d; errCorrected = c; errCode = cd;
    regWrEn = we; regAddr = ad; regWrData = wd;
    @(posedge clk);
    modelStep(ev, u, d, c, cd, we, ad, wd);
    #1;
    errValid = 0; regWrEn = 0; regAddr = 1;
    #1;
    check(tag, regRdData, expStatus());
    check("R8", {63'd0, errSignal}, {63'd0, mSig});
  endtask

  task automatic doReset();
    rstN = 0;
    @(posedge clk);
    @(posedge clk);
    #1 rstN = 1;
    modelReset();
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    doReset();
    // R1
    check("R1", regRdData, 64'd0);
    regAddr = 0; #1;
    check("R1", regRdData, 64'd0);
    check("R1", {63'd0, errSignal}, 64'd0);
    regAddr = 1; #1;

    // R10: report without flags
    step("R10", 1, 0, 0, 0, 8'h5A, 0, 1, 0);

    // R2: every flag combination into an empty record, standard and custom codes
    for (int f = 1; f < 8; f++) begin
      for (int k = 0; k < 2; k++) begin
        doReset();
        step("R2", 1, f[2], f[1], f[0], 8'(k ? 8'h80 + f : f), 0, 1, 0);
      end
    end

    // R3/R5/R6 sweep: stored severity x new severity x rip x invalidate
    for (int s = 1; s < 4; s++)
      for (int n = 0; n < 4; n++)
        for (int r = 0; r < 2; r++)
          for (int inv = 0; inv < 2; inv++) begin
            doReset();
            step("R2", 1, s == 3, s == 2, s == 1, 8'h10 + 8'(s), 0, 1, 0);
            if (r == 0) step("R3", 1, 0, 0, 1, 8'hEE, 0, 1, 0); // drops rip
            step(inv ? "R6" : "R3", 1, n == 3, n == 2, n == 1, 8'hC0 + 8'(n),
                 inv == 1, 0, 3'b100);
          end

    // R4/R5: read-in-progress handshake and readback
    doReset();
    step("R2", 1, 0, 1, 0, 8'h22, 0, 1, 0);
    step("R3", 1, 0, 0, 1, 8'h33, 0, 1, 0);
    step("R5", 0, 0, 0, 0, 0, 1, 0, 3'b100);        // rip=0: ignored
    step("R4", 0, 0, 0, 0, 0, 1, 0, 3'b010);        // set rip
    regAddr = 0; #1;
    check("R4", regRdData, 64'd0);
    step("R4", 0, 0, 0, 0, 0, 1, 0, 3'b111);        // enable, set rip, invalidate
    regAddr = 0; #1;
    check("R4", regRdData, 64'd1);
    regAddr = 1; #1;
    step("R6", 1, 0, 0, 1, 8'h44, 1, 0, 3'b011);    // set rip with capture

    // R9: status writes ignored
    step("R9", 0, 0, 0, 0, 0, 1, 1, 3'b111);
    step("R9", 0, 0, 0, 0, 0, 1, 1, 3'b000);

    // R7/R8: counter sweep through wrap
    doReset();
    step("R4", 0, 0, 0, 0, 0, 1, 0, 3'b001);
    for (int i = 0; i < 40; i++) step("R7", 1, 0, 0, 1, 8'(i), 0, 1, 0);
    step("R8", 1, 1, 0, 1, 8'h99, 0, 1, 0);
    step("R4", 0, 0, 0, 0, 0, 1, 0, 3'b000);
    for (int i = 0; i < 4; i++) step("R8", 1, 0, 0, 1, 8'(i), 0, 1, 0);

    // mixed pseudo-random traffic with same-cycle collisions
    lfsr = 32'hACE1_2357;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R6", lfsr[0], lfsr[1] & lfsr[9], lfsr[2] & lfsr[10], lfsr[3],
           lfsr[19:12], lfsr[4] & lfsr[5], lfsr[6] & lfsr[11], lfsr[9:7]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule